// File: doc/BRIEF.md
# Blocked Pattern History Branch Predictor

This block predicts the direction of every conditional-branch slot in a fetch block with one table lookup. Each table entry holds one 2-bit saturating counter per instruction position, so a single read gives a taken/not-taken vector for the whole block. The entry is selected by XOR-ing the global history register with the block address. The fetch unit reads the vector one cycle after the request, together with the index used. It later uses that index to return resolved outcomes, one position at a time.

The global history advances once per fetch block rather than once per branch. The fetch unit reports how many conditional branches the block consumed and whether the last of them was taken. The history then shifts left by that count, with zeros entering for the not-taken branches and a one in the lowest bit for a taken exit.

After reset a small state machine sweeps the table. It starts in state `ST_CLEAR` (entered on reset), where it writes the weakly-not-taken value 01 into one entry per cycle. When it has written the last index it takes the transition to `ST_ACTIVE`, and it stays there until the next reset. All three request types are ignored while the sweep runs.

Top module: `bpp_blocked`

## Requirements
- R1: After reset is released, `ready` stays low for exactly 2^HIST_W clock edges and then stays high. Every counter then holds 01, so any lookup predicts all positions not taken.
- R2: A lookup accepted in one cycle sets `pred_valid` high in the next cycle, with `pred_idx` equal to the current `ghr` XOR `lk_addr`. Without a lookup, `pred_valid` is low in the next cycle.
- R3: Bit p of `pred_taken` is 1 exactly when counter p of the selected entry is 2 or 3.
- R4: An update increments counter `up_pos` of entry `up_idx` on taken, saturating at 3. It decrements that counter on not taken, saturating at 0. No other counter changes.
- R5: A counter at the strong value 3 that sees one not-taken outcome still predicts taken, and likewise a counter at 0 that sees one taken outcome still predicts not taken.
- R6: A history update with count n (values above BLK_W count as BLK_W) shifts `ghr` left by n. When n > 0, bit 0 becomes `gh_taken` and the other new bits are 0. When n = 0, `ghr` is unchanged.
- R7: A lookup and an update to the same entry in the same cycle return the entry's value before that update. The update becomes visible to the next lookup.
- R8: A lookup issued in the same cycle as a history update forms its index from the history before that update.
- R9: While `ready` is low, history updates, counter updates and lookups have no effect: `ghr` stays 0, `pred_valid` stays low and the table ends the sweep all-01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ready | output | 1 | Table sweep finished, requests accepted |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | HIST_W | Block address bits used for indexing |
| gh_valid | input | 1 | Per-block history update request |
| gh_shift | input | $clog2(BLK_W+1) | Number of conditional branches consumed by the block |
| gh_taken | input | 1 | Block exited on a taken conditional branch |
| up_valid | input | 1 | Resolved-branch counter update |
| up_idx | input | HIST_W | Entry index of the resolved branch |
| up_pos | input | $clog2(BLK_W) | Position of the resolved branch in its block |
| up_taken | input | 1 | Resolved direction |
| pred_valid | output | 1 | Prediction vector valid |
| pred_idx | output | HIST_W | Index used for the prediction |
| pred_taken | output | BLK_W | Per-position taken prediction |
| ghr | output | HIST_W | Current global history |

## Verification
Two pairs of functions can fall in the same cycle. A lookup can coincide with a counter update to the entry it reads, and a lookup can coincide with a history shift that changes the index of later lookups. The random phase draws the update index from the lookup's own index about half the time and raises all three requests together often. A bench model applies the old-value rule for the collision and the pre-shift history for the index, and each prediction is compared with it one cycle later. Directed sequences drive a single counter through both saturation limits and the second-chance steps, and inject requests during the clear sweep.

// File: rtl/bpp_pkg.sv
package bpp_pkg;

    typedef enum logic [0:0] {
        ST_CLEAR  = 1'b0,
        ST_ACTIVE = 1'b1
    } tbl_state_e;

    localparam logic [1:0] CTR_INIT = 2'b01;

    // Saturating 2-bit up/down step.
    function automatic logic [1:0] ctr_next(input logic [1:0] c, input logic taken);
        logic [1:0] r;
        if (taken) r = (c == 2'b11) ? c : c + 2'd1;
        else       r = (c == 2'b00) ? c : c - 2'd1;
        return r;
    endfunction

endpackage

// File: rtl/bpp_ghr.sv
module bpp_ghr #(
    parameter int HIST_W  = 10,
    parameter int BLK_W   = 8,
    localparam int SHIFT_W = $clog2(BLK_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               gh_valid,
    input  logic [SHIFT_W-1:0] gh_shift,
    input  logic               gh_taken,
    output logic [HIST_W-1:0]  ghr
);

    logic [SHIFT_W-1:0] n_eff;
    logic [HIST_W-1:0]  ghr_nx;

    always_comb begin
        n_eff = (gh_shift > SHIFT_W'(BLK_W)) ? SHIFT_W'(BLK_W) : gh_shift;
        ghr_nx = ghr << n_eff;
        if (n_eff != '0) ghr_nx[0] = gh_taken;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  ghr <= '0;
        else if (enable && gh_valid) ghr <= ghr_nx;
    end

    // R6: no request or zero count leaves the history untouched.
    assert_ghr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!gh_valid || gh_shift == '0) |=> $stable(ghr));

    // R6: a non-zero shift places the exit direction in bit 0.
    assert_ghr_lsb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && gh_valid && gh_shift != '0) |=> (ghr[0] == $past(gh_taken)));

    // R9: history stays cleared while the table is being swept.
    assert_ghr_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable) |=> (ghr == '0 || $past(enable)));

endmodule

// File: rtl/bpp_table.sv
module bpp_table
    import bpp_pkg::*;
#(
    parameter int HIST_W = 10,
    parameter int BLK_W  = 8,
    localparam int DEPTH = 1 << HIST_W,
    localparam int POS_W = $clog2(BLK_W),
    localparam int ENT_W = 2 * BLK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              active,
    input  logic              rd_valid,
    input  logic [HIST_W-1:0] rd_idx,
    input  logic              up_valid,
    input  logic [HIST_W-1:0] up_idx,
    input  logic [POS_W-1:0]  up_pos,
    input  logic              up_taken,
    output logic              pred_valid,
    output logic [HIST_W-1:0] pred_idx,
    output logic [BLK_W-1:0]  pred_taken
);

    tbl_state_e        state, state_nx;
    logic [HIST_W-1:0] clr_ptr;
    logic [ENT_W-1:0]  mem [DEPTH];
    logic [ENT_W-1:0]  rd_entry, up_old, up_new;
    logic [BLK_W-1:0]  rd_taken;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CLEAR:  if (clr_ptr == '1) state_nx = ST_ACTIVE;
            ST_ACTIVE: state_nx = ST_ACTIVE;
            default:   state_nx = ST_CLEAR;
        endcase
    end

    // State register and sweep pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_CLEAR;
            clr_ptr <= '0;
        end else begin
            state   <= state_nx;
            clr_ptr <= (state == ST_CLEAR) ? clr_ptr + 1'b1 : clr_ptr;
        end
    end

    assign active   = (state == ST_ACTIVE);
    assign rd_entry = mem[rd_idx];
    assign up_old   = mem[up_idx];

    for (genvar p = 0; p < BLK_W; p++) begin : g_pos
        assign rd_taken[p] = rd_entry[2*p+1];
        assign up_new[2*p +: 2] = (up_pos == POS_W'(p))
                                ? ctr_next(up_old[2*p +: 2], up_taken)
                                : up_old[2*p +: 2];
    end

    // Storage: sweep writes have priority; updates only when active.
    always_ff @(posedge clk) begin
        if (state == ST_CLEAR)  mem[clr_ptr] <= {BLK_W{CTR_INIT}};
        else if (up_valid)      mem[up_idx]  <= up_new;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_valid <= 1'b0;
            pred_idx   <= '0;
            pred_taken <= '0;
        end else begin
            pred_valid <= rd_valid && active;
            if (rd_valid && active) begin
                pred_idx   <= rd_idx;
                pred_taken <= rd_taken;
            end
        end
    end

    // R1: once active, the table never returns to the sweep.
    assert_stay_active_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE) |=> (state == ST_ACTIVE));

    // R2: an accepted lookup produces a prediction one cycle later.
    assert_pred_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && active) |=> (pred_valid && pred_idx == $past(rd_idx)));

    // R2 / R9: no accepted lookup, no prediction.
    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && active) |=> !pred_valid);

    // R1: the sweep pointer only moves while clearing.
    assert_ptr_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE) |=> $stable(clr_ptr));

endmodule

// File: rtl/bpp_blocked.sv
module bpp_blocked #(
    parameter int HIST_W  = 10,
    parameter int BLK_W   = 8,
    localparam int SHIFT_W = $clog2(BLK_W + 1),
    localparam int POS_W   = $clog2(BLK_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               ready,
    input  logic               lk_valid,
    input  logic [HIST_W-1:0]  lk_addr,
    input  logic               gh_valid,
    input  logic [SHIFT_W-1:0] gh_shift,
    input  logic               gh_taken,
    input  logic               up_valid,
    input  logic [HIST_W-1:0]  up_idx,
    input  logic [POS_W-1:0]   up_pos,
    input  logic               up_taken,
    output logic               pred_valid,
    output logic [HIST_W-1:0]  pred_idx,
    output logic [BLK_W-1:0]   pred_taken,
    output logic [HIST_W-1:0]  ghr
);

    logic              active;
    logic [HIST_W-1:0] rd_idx;

    // Index formed from the history before any same-cycle shift (R8).
    assign rd_idx = ghr ^ lk_addr;
    assign ready  = active;

    bpp_ghr #(.HIST_W(HIST_W), .BLK_W(BLK_W)) u_ghr (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (active),
        .gh_valid (gh_valid),
        .gh_shift (gh_shift),
        .gh_taken (gh_taken),
        .ghr      (ghr)
    );

    bpp_table #(.HIST_W(HIST_W), .BLK_W(BLK_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .rd_valid   (lk_valid),
        .rd_idx     (rd_idx),
        .up_valid   (up_valid),
        .up_idx     (up_idx),
        .up_pos     (up_pos),
        .up_taken   (up_taken),
        .pred_valid (pred_valid),
        .pred_idx   (pred_idx),
        .pred_taken (pred_taken)
    );

endmodule

// File: tb/bpp_blocked_bench.sv
module bpp_blocked_bench;

    localparam int HIST_W  = 10;
    localparam int BLK_W   = 8;
    localparam int DEPTH   = 1 << HIST_W;
    localparam int SHIFT_W = $clog2(BLK_W + 1);
    localparam int POS_W   = $clog2(BLK_W);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ready;
    logic lk_valid = 0;
    logic [HIST_W-1:0] lk_addr = '0;
    logic gh_valid = 0;
    logic [SHIFT_W-1:0] gh_shift = '0;
    logic gh_taken = 0;
    logic up_valid = 0;
    logic [HIST_W-1:0] up_idx = '0;
    logic [POS_W-1:0] up_pos = '0;
    logic up_taken = 0;
    logic pred_valid;
    logic [HIST_W-1:0] pred_idx;
    logic [BLK_W-1:0] pred_taken;
    logic [HIST_W-1:0] ghr;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [1:0] mref [DEPTH][BLK_W];
    logic [HIST_W-1:0] mghr = '0;

    always #5 clk = ~clk;

    bpp_blocked #(.HIST_W(HIST_W), .BLK_W(BLK_W)) u_bpp_blocked (
        .clk(clk), .rst_n(rst_n), .ready(ready),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .gh_valid(gh_valid), .gh_shift(gh_shift), .gh_taken(gh_taken),
        .up_valid(up_valid), .up_idx(up_idx), .up_pos(up_pos), .up_taken(up_taken),
        .pred_valid(pred_valid), .pred_idx(pred_idx), .pred_taken(pred_taken),
        .ghr(ghr)
    );

    function automatic logic [HIST_W-1:0] ghr_after(logic [HIST_W-1:0] g, int n, logic t);
        int k = (n > BLK_W) ? BLK_W : n;
        logic [HIST_W-1:0] r = g;
        for (int i = 0; i < k; i++) r = {r[HIST_W-2:0], 1'b0};
        if (k > 0) r[0] = t;
        return r;
    endfunction

    function automatic logic [1:0] sat_step(logic [1:0] c, logic t);
        int v = int'(c) + (t ? 1 : -1);
        if (v > 3) v = 3;
        if (v < 0) v = 0;
        return 2'(v);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(logic lv, logic [HIST_W-1:0] la, logic gv, logic [SHIFT_W-1:0] gs,
                         logic gt, logic uv, logic [HIST_W-1:0] ui, logic [POS_W-1:0] up,
                         logic ut);
        lk_valid = lv; lk_addr = la; gh_valid = gv; gh_shift = gs; gh_taken = gt;
        up_valid = uv; up_idx = ui; up_pos = up; up_taken = ut;
    endtask

    // One active cycle: predict from the model, advance it, compare after the edge.
    task automatic cyc(string tag);
        logic [HIST_W-1:0] e_idx;
        logic [BLK_W-1:0] e_tk;
        logic e_v;
        string itag;
        e_v = lk_valid;
        e_idx = mghr ^ lk_addr;
        for (int p = 0; p < BLK_W; p++) e_tk[p] = mref[e_idx][p][1];
        itag = (lk_valid && gh_valid) ? "R8" : "R2";
        if (up_valid) mref[up_idx][up_pos] = sat_step(mref[up_idx][up_pos], up_taken);
        if (gh_valid) mghr = ghr_after(mghr, int'(gh_shift), gh_taken);
        @(posedge clk);
        @(negedge clk);
        chk("R2 pred_valid", 32'(pred_valid), 32'(e_v));
        if (e_v) begin
            chk(itag, 32'(pred_idx), 32'(e_idx));
            chk(tag, 32'(pred_taken), 32'(e_tk));
        end
        chk("R6 ghr", 32'(ghr), 32'(mghr));
    endtask

    // Look up entry t without changing anything, then judge its position-3 bit.
    task automatic probe(string tag, logic [HIST_W-1:0] t);
        drive(1, mghr ^ t, 0, '0, 0, 0, '0, '0, 0);
        cyc(tag);
    endtask

    task automatic bump(logic [HIST_W-1:0] t, logic dir);
        drive(0, '0, 0, '0, 0, 1, t, POS_W'(3), dir);
        cyc("R4");
    endtask

    initial begin
        int n;
        void'($urandom(32'd2024));
        for (int i = 0; i < DEPTH; i++)
            for (int p = 0; p < BLK_W; p++) mref[i][p] = 2'b01;

        repeat (3) @(negedge clk);
        chk("R1 ready in reset", 32'(ready), 0);
        chk("R6 ghr in reset", 32'(ghr), 0);
        chk("R2 pred_valid in reset", 32'(pred_valid), 0);
        rst_n = 1'b1;

        // Sweep: count edges until ready, injecting requests that must be ignored.
        n = 0;
        while (!ready && n < 3 * DEPTH) begin
            if (n == 10 || n == 11) drive(0, '0, 0, '0, 0, 1, '0, '0, 1);
            else if (n == 12) drive(1, 10'h5, 1, SHIFT_W'(3), 1, 0, '0, '0, 0);
            else drive(0, '0, 0, '0, 0, 0, '0, '0, 0);
            @(posedge clk);
            @(negedge clk);
            n++;
            if (n == 13) begin
                chk("R9 ghr during clear", 32'(ghr), 0);
                chk("R9 pred_valid during clear", 32'(pred_valid), 0);
            end
        end
        chk("R1 clear length", 32'(n), 32'(DEPTH));
        drive(0, '0, 0, '0, 0, 0, '0, '0, 0);

        // R9: updates to entry 0 during the sweep left it all-01.
        drive(1, '0, 0, '0, 0, 0, '0, '0, 0);
        cyc("R9");
        // R1: far entry also all not-taken.
        drive(1, '1, 0, '0, 0, 0, '0, '0, 0);
        cyc("R1");

        // R4/R5 upward: 01->10->11->11(sat)->10 (second chance)->01.
        bump(10'h2A, 1); probe("R3", 10'h2A);
        bump(10'h2A, 1); bump(10'h2A, 1); bump(10'h2A, 1); probe("R4", 10'h2A);
        bump(10'h2A, 0); probe("R5", 10'h2A);
        bump(10'h2A, 0); probe("R5", 10'h2A);
        // Downward: 01->00->00(sat)->01 (second chance)->10.
        bump(10'h2A, 0); bump(10'h2A, 0); bump(10'h2A, 1); probe("R5", 10'h2A);
        bump(10'h2A, 1); probe("R4", 10'h2A);

        // R7 directed: lookup and update to the same entry together.
        drive(1, mghr ^ 10'h2A, 0, '0, 0, 1, 10'h2A, POS_W'(3), 0);
        cyc("R7");
        probe("R7", 10'h2A);

        // R6 directed: zero shift, over-range shift, full shift.
        drive(0, '0, 1, SHIFT_W'(3), 1, 0, '0, '0, 0); cyc("R6");
        drive(0, '0, 1, '0, 1, 0, '0, '0, 0); cyc("R6");
        drive(0, '0, 1, SHIFT_W'(15), 1, 0, '0, '0, 0); cyc("R6");
        drive(0, '0, 1, SHIFT_W'(BLK_W), 0, 0, '0, '0, 0); cyc("R6");
        // R8 directed: lookup with a same-cycle shift.
        drive(1, 10'h0F, 1, SHIFT_W'(2), 1, 0, '0, '0, 0); cyc("R8");

        // Constrained random phase on a small address set to reach saturation.
        for (int it = 0; it < 4000; it++) begin
            logic [HIST_W-1:0] a, ui;
            logic lv, uv, gv, coll;
            lv = ($urandom % 4) != 0;
            a  = HIST_W'($urandom % 8);
            gv = ($urandom % 3) == 0;
            uv = ($urandom % 2) == 0;
            coll = ($urandom % 2) == 0;
            ui = coll ? (mghr ^ a) : HIST_W'($urandom % 8);
            drive(lv, a, gv, SHIFT_W'($urandom % (BLK_W + 3)), 1'($urandom),
                  uv, ui, POS_W'($urandom), 1'($urandom));
            cyc((lv && uv && coll) ? "R7" : "R3");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule